// File: doc/BRIEF.md
# Keypad Controller Command Front End

This block interprets the byte stream that a serial target interface hands over after the bit-level protocol has been decoded. It sees four kinds of events: the start of a write transfer, the start of a read transfer, a received data byte, and a strobe that asks for the next byte to return. In a write transfer the first byte picks a command and every later byte is a parameter of that command. In a read transfer the block returns bytes for the command picked by the last write.

The block holds the setup registers of a keypad controller: configuration, active time, debounce time, matrix size, clock setting, and three 16-bit GPIO words (pull select, direction and state). It checks parameters, collects faults in a sticky error register, and keeps an interrupt status word. An active-low interrupt line is low while that word is nonzero. Key events and PWM-finished events from neighbouring blocks set their status bits. A configuration write sends a one-cycle flush pulse to the key FIFO.

Top module: `kpc_frontend`

## Requirements
- R1: Any `wr_start` or `rd_start` resets the byte counter. In a write, byte 0 is latched as the current command, and byte n (n ≥ 1) is taken as parameter n−1 of that command.
- R2: When a command has taken its last parameter, the current command becomes 0xFF. Any further written byte then sets error bit 0 (bad parameter) and status bit 3.
- R3: Command 0x83 with parameter 0xAA reloads the reset values of configuration, interrupt status, active time, debounce, size and clock. The GPIO words and the error register keep their values. Any other parameter is a bad parameter.
- R4: After `rst_n` the values are: configuration 0x80, status 0x10, active time 125, debounce 3, size 0x33, clock 0x08, GPIO words 0, error 0.
- R5: Status bit 0 is set by `key_evt`. Bits 7:5 are set by `pwm_done[2:0]`. Bit 4 means not initialised and bit 3 means error. `irq_n` is low exactly when status is nonzero.
- R6: Reading command 0x82 returns the status. Each read strobe then clears the status, unless bit 4 is set.
- R7: Debounce write (0x8F) stores its parameter. A value of zero also flags a bad parameter.
- R8: Size write (0x90) stores its parameter. A bad parameter is flagged unless the low nibble lies in 3..12 and the high nibble in 3..8. Command 0x91 reads the size back.
- R9: Clock write (0x93) stores its parameter. A bad parameter is flagged when the low two bits are 01 or 10. Clock read (0x94) returns the stored value with bits 1:0 forced to 10.
- R10: Pull (0x84), direction (0x85) and state (0x86) writes take two parameters. The first replaces the 16-bit word with the byte zero-extended. The second is ORed into bits 15:8, and then the command closes. Direction reads (0x87) and state reads (0x88) return the low byte first and then the high byte.
- R11: A parameter byte for a command that accepts no writes, or a read strobe for a command that has no read, sets error bit 1. Every error also sets status bit 3.
- R12: ID read (0x80) returns 0x00 and then 0x04, with zero after that. Configuration read (0x92) returns the configuration's low nibble. Error read (0x8C) returns the error register.
- R13: Configuration write (0x81) stores the byte, clears the status, raises `fifo_flush` for exactly one cycle, and closes the command.
- R14: Active time write (0x8B) stores its parameter without checking it and closes the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Start of a write transfer |
| rd_start | input | 1 | Start of a read transfer |
| wr_valid | input | 1 | `wr_byte` holds a received byte |
| wr_byte | input | 8 | Received byte |
| rd_strobe | input | 1 | The current `rd_byte` is consumed |
| rd_byte | output | 8 | Response byte for the current command and byte index |
| key_evt | input | 1 | Key event pushed into the FIFO |
| pwm_done | input | 3 | PWM channel finished, one bit per channel |
| irq_n | output | 1 | Active-low interrupt |
| fifo_flush | output | 1 | One-cycle key FIFO flush |
| cfg_reg | output | 8 | Configuration register |
| act_time | output | 8 | Active time |
| debounce | output | 8 | Debounce time |
| key_size | output | 8 | Keypad matrix size |
| clk_cfg | output | 8 | Clock setting |
| gpio_pull | output | 16 | GPIO pull select |
| gpio_dir | output | 16 | GPIO direction |
| gpio_state | output | 16 | GPIO state |

## Verification
A command latch that fails to close shows up on the next surplus byte. That byte then writes a register output instead of pulling `irq_n` low, and the difference is visible one cycle after the byte. A wrong byte counter sends parameters to the wrong half of a GPIO word or makes the ID read return bytes in the wrong order, and this appears on `rd_byte` within the same transfer. A status clear that ignores the not-initialised bit releases `irq_n` one cycle after the read strobe. Broken validation shows as an `irq_n` level that is wrong right after the offending byte.

// File: rtl/kpc_pkg.sv
package kpc_pkg;
    localparam logic [7:0] CMD_ID_RD    = 8'h80;
    localparam logic [7:0] CMD_CFG_WR   = 8'h81;
    localparam logic [7:0] CMD_STAT_RD  = 8'h82;
    localparam logic [7:0] CMD_RESET    = 8'h83;
    localparam logic [7:0] CMD_PULL_WR  = 8'h84;
    localparam logic [7:0] CMD_DIR_WR   = 8'h85;
    localparam logic [7:0] CMD_STATE_WR = 8'h86;
    localparam logic [7:0] CMD_DIR_RD   = 8'h87;
    localparam logic [7:0] CMD_STATE_RD = 8'h88;
    localparam logic [7:0] CMD_ACT_WR   = 8'h8B;
    localparam logic [7:0] CMD_ERR_RD   = 8'h8C;
    localparam logic [7:0] CMD_DEB_WR   = 8'h8F;
    localparam logic [7:0] CMD_SIZE_WR  = 8'h90;
    localparam logic [7:0] CMD_SIZE_RD  = 8'h91;
    localparam logic [7:0] CMD_CFG_RD   = 8'h92;
    localparam logic [7:0] CMD_CLK_WR   = 8'h93;
    localparam logic [7:0] CMD_CLK_RD   = 8'h94;
    localparam logic [7:0] CMD_CLOSED   = 8'hFF;

    localparam logic [7:0] RESET_KEY    = 8'hAA;

    // status bit positions
    localparam int ST_KEY   = 0;
    localparam int ST_ERR   = 3;
    localparam int ST_NOINI = 4;
    localparam int ST_PWM0  = 5;

    // error bit positions
    localparam int ER_PARAM = 0;
    localparam int ER_CMD   = 1;

    localparam logic [7:0] RV_CFG   = 8'h80;
    localparam logic [7:0] RV_STAT  = 8'h10;
    localparam logic [7:0] RV_ACT   = 8'd125;
    localparam logic [7:0] RV_DEB   = 8'd3;
    localparam logic [7:0] RV_SIZE  = 8'h33;
    localparam logic [7:0] RV_CLK   = 8'h08;
endpackage

// File: rtl/kpc_param_check.sv
module kpc_param_check
    import kpc_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int DIM_MIN  = 3,
    parameter int LO_MAX   = 12,
    parameter int HI_MAX   = 8
) (
    input  logic [7:0]       cmd,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    output logic             accepts,
    output logic             bad_par,
    output logic             closes
);
    localparam logic [3:0] NIB_MIN = 4'(DIM_MIN);
    localparam logic [3:0] NIB_LO  = 4'(LO_MAX);
    localparam logic [3:0] NIB_HI  = 4'(HI_MAX);

    logic [3:0] lo_nib, hi_nib;
    assign lo_nib = data[3:0];
    assign hi_nib = data[7:4];

    always_comb begin
        accepts = 1'b1;
        bad_par = 1'b0;
        closes  = 1'b1;
        case (cmd)
            CMD_CFG_WR, CMD_ACT_WR: ;
            CMD_RESET:   bad_par = (data != RESET_KEY);
            CMD_PULL_WR, CMD_DIR_WR, CMD_STATE_WR:
                closes = (idx != '0);
            CMD_DEB_WR:  bad_par = (data == 8'h00);
            CMD_SIZE_WR: bad_par = (lo_nib < NIB_MIN) || (lo_nib > NIB_LO) ||
                                   (hi_nib < NIB_MIN) || (hi_nib > NIB_HI);
            CMD_CLK_WR:  bad_par = data[1] ^ data[0];
            CMD_CLOSED: begin
                bad_par = 1'b1;
                closes  = 1'b0;
            end
            default: begin
                accepts = 1'b0;
                closes  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/kpc_read_mux.sv
module kpc_read_mux
    import kpc_pkg::*;
#(
    parameter int          IDX_W   = 4,
    parameter logic [15:0] CHIP_ID = 16'h0400
) (
    input  logic [7:0]       cmd,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       stat,
    input  logic [7:0]       err,
    input  logic [7:0]       cfg,
    input  logic [7:0]       size,
    input  logic [7:0]       clk_set,
    input  logic [15:0]      dir,
    input  logic [15:0]      state,
    output logic [7:0]       data,
    output logic             known
);
    function automatic logic [7:0] pick(input logic [15:0] w, input logic [IDX_W-1:0] i);
        if (i == '0)                   return w[7:0];
        else if (i == IDX_W'(1))       return w[15:8];
        else                           return 8'h00;
    endfunction

    always_comb begin
        known = 1'b1;
        data  = 8'h00;
        case (cmd)
            CMD_ID_RD:    data = pick(CHIP_ID, idx);
            CMD_STAT_RD:  data = stat;
            CMD_DIR_RD:   data = pick(dir, idx);
            CMD_STATE_RD: data = pick(state, idx);
            CMD_ERR_RD:   data = err;
            CMD_SIZE_RD:  data = size;
            CMD_CFG_RD:   data = {4'h0, cfg[3:0]};
            CMD_CLK_RD:   data = {clk_set[7:2], 2'b10};
            default:      known = 1'b0;
        endcase
    end
endmodule

// File: rtl/kpc_frontend.sv
module kpc_frontend
    import kpc_pkg::*;
#(
    parameter int          CNT_W   = 4,
    parameter logic [15:0] CHIP_ID = 16'h0400,
    parameter int          DIM_MIN = 3,
    parameter int          LO_MAX  = 12,
    parameter int          HI_MAX  = 8,
    parameter int          N_PWM   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_start,
    input  logic             rd_start,
    input  logic             wr_valid,
    input  logic [7:0]       wr_byte,
    input  logic             rd_strobe,
    output logic [7:0]       rd_byte,
    input  logic             key_evt,
    input  logic [N_PWM-1:0] pwm_done,
    output logic             irq_n,
    output logic             fifo_flush,
    output logic [7:0]       cfg_reg,
    output logic [7:0]       act_time,
    output logic [7:0]       debounce,
    output logic [7:0]       key_size,
    output logic [7:0]       clk_cfg,
    output logic [15:0]      gpio_pull,
    output logic [15:0]      gpio_dir,
    output logic [15:0]      gpio_state
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int PAD_W = 8 - ST_PWM0 - N_PWM;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       cmd;
        logic [7:0]       stat;
        logic [7:0]       err;
        logic [7:0]       cfg;
        logic [7:0]       act;
        logic [7:0]       deb;
        logic [7:0]       size;
        logic [7:0]       clk_set;
        logic [15:0]      pull;
        logic [15:0]      dir;
        logic [15:0]      state;
        logic             flush;
    } core_t;

    core_t core_d, core_q;

    logic [CNT_W-1:0] par_idx;
    logic             wr_accepts, wr_bad, wr_closes;
    logic [7:0]       mux_data;
    logic             mux_known;
    logic [7:0]       evt_bits;

    assign par_idx = core_q.cnt - CNT_W'(1);

    kpc_param_check #(
        .IDX_W  (CNT_W),
        .DIM_MIN(DIM_MIN),
        .LO_MAX (LO_MAX),
        .HI_MAX (HI_MAX)
    ) i_check (
        .cmd    (core_q.cmd),
        .idx    (par_idx),
        .data   (wr_byte),
        .accepts(wr_accepts),
        .bad_par(wr_bad),
        .closes (wr_closes)
    );

    kpc_read_mux #(
        .IDX_W  (CNT_W),
        .CHIP_ID(CHIP_ID)
    ) i_rdmux (
        .cmd    (core_q.cmd),
        .idx    (core_q.cnt),
        .stat   (core_q.stat),
        .err    (core_q.err),
        .cfg    (core_q.cfg),
        .size   (core_q.size),
        .clk_set(core_q.clk_set),
        .dir    (core_q.dir),
        .state  (core_q.state),
        .data   (mux_data),
        .known  (mux_known)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign evt_bits = {{PAD_W{1'b0}}, pwm_done, 4'b0000, key_evt};
        end else begin : g_nopad
            assign evt_bits = {pwm_done, 4'b0000, key_evt};
        end
    endgenerate

    always_comb begin
        logic [CNT_W-1:0] cnt_inc;
        logic             raise_par, raise_cmd;
        core_d    = core_q;
        core_d.flush = 1'b0;
        raise_par = 1'b0;
        raise_cmd = 1'b0;
        cnt_inc   = (core_q.cnt == CNT_MAX) ? core_q.cnt : core_q.cnt + CNT_W'(1);

        if (wr_start || rd_start) begin
            core_d.cnt = '0;
        end else if (wr_valid) begin
            core_d.cnt = cnt_inc;
            if (core_q.cnt == '0) begin
                core_d.cmd = wr_byte;
            end else if (!wr_accepts) begin
                raise_cmd = 1'b1;
            end else begin
                raise_par = wr_bad;
                case (core_q.cmd)
                    CMD_CFG_WR: begin
                        core_d.cfg   = wr_byte;
                        core_d.stat  = 8'h00;
                        core_d.flush = 1'b1;
                    end
                    CMD_RESET: begin
                        if (!wr_bad) begin
                            core_d.cfg     = RV_CFG;
                            core_d.stat    = RV_STAT;
                            core_d.act     = RV_ACT;
                            core_d.deb     = RV_DEB;
                            core_d.size    = RV_SIZE;
                            core_d.clk_set = RV_CLK;
                        end
                    end
                    CMD_PULL_WR:
                        core_d.pull = (par_idx == '0) ? {8'h00, wr_byte}
                                                      : core_q.pull | {wr_byte, 8'h00};
                    CMD_DIR_WR:
                        core_d.dir = (par_idx == '0) ? {8'h00, wr_byte}
                                                     : core_q.dir | {wr_byte, 8'h00};
                    CMD_STATE_WR:
                        core_d.state = (par_idx == '0) ? {8'h00, wr_byte}
                                                       : core_q.state | {wr_byte, 8'h00};
                    CMD_ACT_WR:  core_d.act     = wr_byte;
                    CMD_DEB_WR:  core_d.deb     = wr_byte;
                    CMD_SIZE_WR: core_d.size    = wr_byte;
                    CMD_CLK_WR:  core_d.clk_set = wr_byte;
                    default: ;
                endcase
                if (wr_closes) core_d.cmd = CMD_CLOSED;
            end
        end else if (rd_strobe) begin
            core_d.cnt = cnt_inc;
            if (!mux_known) begin
                raise_cmd = 1'b1;
            end else if (core_q.cmd == CMD_STAT_RD && !core_q.stat[ST_NOINI]) begin
                core_d.stat = 8'h00;
            end
        end

        if (raise_par) core_d.err[ER_PARAM] = 1'b1;
        if (raise_cmd) core_d.err[ER_CMD]   = 1'b1;
        if (raise_par || raise_cmd) core_d.stat[ST_ERR] = 1'b1;
        core_d.stat = core_d.stat | evt_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.cnt     <= '0;
            core_q.cmd     <= CMD_CLOSED;
            core_q.stat    <= RV_STAT;
            core_q.err     <= 8'h00;
            core_q.cfg     <= RV_CFG;
            core_q.act     <= RV_ACT;
            core_q.deb     <= RV_DEB;
            core_q.size    <= RV_SIZE;
            core_q.clk_set <= RV_CLK;
            core_q.pull    <= 16'h0000;
            core_q.dir     <= 16'h0000;
            core_q.state   <= 16'h0000;
            core_q.flush   <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign rd_byte    = mux_data;
    assign irq_n      = (core_q.stat == 8'h00);
    assign fifo_flush = core_q.flush;
    assign cfg_reg    = core_q.cfg;
    assign act_time   = core_q.act;
    assign debounce   = core_q.deb;
    assign key_size   = core_q.size;
    assign clk_cfg    = core_q.clk_set;
    assign gpio_pull  = core_q.pull;
    assign gpio_dir   = core_q.dir;
    assign gpio_state = core_q.state;

    // A byte under the closed command must raise the bad-parameter flag and the error status.
    assert_closed_surplus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_start && !rd_start && core_q.cnt != '0 && core_q.cmd == CMD_CLOSED)
        |=> (core_q.err[ER_PARAM] && !irq_n));

    // The not-initialised flag survives a status read.
    assert_noinit_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !wr_start && !rd_start && !wr_valid &&
         core_q.cmd == CMD_STAT_RD && core_q.stat[ST_NOINI])
        |=> core_q.stat[ST_NOINI]);

    // The flush pulse never lasts longer than one cycle.
    assert_flush_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush);

    // Any new error bit comes with the error status bit.
    assert_err_sets_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_q.err) |-> core_q.stat[ST_ERR]);

    // The high byte of a GPIO word closes its command.
    assert_gpio_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_start && !rd_start && core_q.cnt == CNT_W'(2) &&
         (core_q.cmd == CMD_DIR_WR || core_q.cmd == CMD_PULL_WR || core_q.cmd == CMD_STATE_WR))
        |=> core_q.cmd == CMD_CLOSED);
endmodule

// File: tb/test_kpc_frontend.sv
module test_kpc_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0, rd_start = 1'b0, wr_valid = 1'b0, rd_strobe = 1'b0;
    logic [7:0]  wr_byte = 8'h00;
    logic [7:0]  rd_byte;
    logic        key_evt = 1'b0;
    logic [2:0]  pwm_done = 3'b000;
    logic        irq_n, fifo_flush;
    logic [7:0]  cfg_reg, act_time, debounce, key_size, clk_cfg;
    logic [15:0] gpio_pull, gpio_dir, gpio_state;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    kpc_frontend i_kpc_frontend (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_strobe(rd_strobe), .rd_byte(rd_byte),
        .key_evt(key_evt), .pwm_done(pwm_done), .irq_n(irq_n), .fifo_flush(fifo_flush),
        .cfg_reg(cfg_reg), .act_time(act_time), .debounce(debounce), .key_size(key_size),
        .clk_cfg(clk_cfg), .gpio_pull(gpio_pull), .gpio_dir(gpio_dir), .gpio_state(gpio_state)
    );

    // write cmd, write data, read cmd, expected read byte
    localparam logic [31:0] TBL [0:5] = '{
        32'h90_44_91_44,
        32'h90_C3_91_C3,
        32'h93_0B_94_0A,
        32'h93_09_94_0A,
        32'h93_00_94_02,
        32'h81_2A_92_0A
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic begin_wr();
        wr_start = 1'b1; @(negedge clk); wr_start = 1'b0;
    endtask

    task automatic begin_rd();
        rd_start = 1'b1; @(negedge clk); rd_start = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        wr_valid = 1'b1; wr_byte = b; @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic take(output logic [7:0] b);
        rd_strobe = 1'b1; #1; b = rd_byte; @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] c, input logic [7:0] p);
        begin_wr(); put(c); put(p);
    endtask

    task automatic wr2(input logic [7:0] c, input logic [7:0] p0, input logic [7:0] p1);
        begin_wr(); put(c); put(p0); put(p1);
    endtask

    task automatic rd1(input logic [7:0] c, output logic [7:0] b);
        begin_wr(); put(c); begin_rd(); take(b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b, b2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 reset values
        check("R4 cfg", 16'(cfg_reg), 16'h80);
        check("R4 act", 16'(act_time), 16'd125);
        check("R4 deb", 16'(debounce), 16'h03);
        check("R4 size", 16'(key_size), 16'h33);
        check("R4 clk", 16'(clk_cfg), 16'h08);
        check("R4 gpio", gpio_dir | gpio_pull | gpio_state, 16'h0000);
        check("R4 R5 irq_n", 16'(irq_n), 16'h0);

        // R6 not-initialised survives reads
        rd1(8'h82, b);
        check("R6 status", 16'(b), 16'h10);
        rd1(8'h82, b);
        check("R6 status kept", 16'(b), 16'h10);

        // R12 ID bytes
        begin_wr(); put(8'h80); begin_rd(); take(b); take(b2);
        check("R12 id lo", 16'(b), 16'h00);
        check("R12 id hi", 16'(b2), 16'h04);

        // R13 configuration write
        wr1(8'h81, 8'h05);
        check("R13 flush pulse", 16'(fifo_flush), 16'h1);
        @(negedge clk);
        check("R13 flush ends", 16'(fifo_flush), 16'h0);
        check("R13 irq released", 16'(irq_n), 16'h1);
        rd1(8'h92, b);
        check("R12 cfg nibble", 16'(b), 16'h05);

        // table walk: R8 R9 R12 R13
        for (int i = 0; i < 6; i++) begin
            wr1(TBL[i][31:24], TBL[i][23:16]);
            rd1(TBL[i][15:8], b);
            check($sformatf("R8 R9 R12 table %0d", i), 16'(b), 16'(TBL[i][7:0]));
        end
        check("R13 irq after cfg", 16'(irq_n), 16'h1);
        rd1(8'h8C, b);
        check("R8 R9 R12 error reg", 16'(b), 16'h01);

        // R2 surplus byte
        begin_wr(); put(8'h90); put(8'h44); put(8'h00);
        check("R2 irq low", 16'(irq_n), 16'h0);
        rd1(8'h82, b);
        check("R2 status", 16'(b), 16'h08);
        check("R6 cleared", 16'(irq_n), 16'h1);

        // R11 unknown write and unknown read
        wr1(8'h70, 8'h01);
        rd1(8'h8C, b);
        check("R11 error reg", 16'(b), 16'h03);
        rd1(8'h82, b);
        check("R11 status", 16'(b), 16'h08);
        rd1(8'h8B, b);
        rd1(8'h82, b);
        check("R11 read unknown", 16'(b), 16'h08);

        // R7 debounce
        wr1(8'h8F, 8'h00);
        check("R7 stored zero", 16'(debounce), 16'h00);
        rd1(8'h82, b);
        check("R7 zero flagged", 16'(b), 16'h08);
        wr1(8'h8F, 8'h06);
        rd1(8'h82, b);
        check("R7 ok value", 16'({b, debounce}), 16'h0006);

        // R14 active time
        wr1(8'h8B, 8'h20);
        rd1(8'h82, b);
        check("R14 act", 16'({b, act_time}), 16'h0020);

        // R10 GPIO words
        wr2(8'h85, 8'h34, 8'h12);
        check("R10 dir", gpio_dir, 16'h1234);
        wr2(8'h85, 8'hF0, 8'h01);
        check("R10 dir replace", gpio_dir, 16'h01F0);
        begin_wr(); put(8'h87); begin_rd(); take(b); take(b2);
        check("R10 dir read", {b2, b}, 16'h01F0);
        wr2(8'h84, 8'hAA, 8'h55);
        check("R10 pull", gpio_pull, 16'h55AA);
        wr2(8'h86, 8'h01, 8'h80);
        begin_wr(); put(8'h88); begin_rd(); take(b); take(b2);
        check("R10 state read", {b2, b}, 16'h8001);
        rd1(8'h82, b);
        check("R10 no error", 16'(b), 16'h00);
        begin_wr(); put(8'h84); put(8'h00); put(8'h00); put(8'h07);
        check("R10 pull closed", gpio_pull, 16'h0000);
        rd1(8'h82, b);
        check("R10 R2 extra byte", 16'(b), 16'h08);

        // R1 restart mid-command
        begin_wr(); put(8'h8B); begin_wr(); put(8'h8F); put(8'h07);
        check("R1 restart", 16'({act_time, debounce}), 16'h2007);

        // R5 events
        @(negedge clk); key_evt = 1'b1; @(negedge clk); key_evt = 1'b0;
        check("R5 key irq", 16'(irq_n), 16'h0);
        rd1(8'h82, b);
        check("R5 key bit", 16'(b), 16'h01);
        pwm_done = 3'b100; @(negedge clk); pwm_done = 3'b000;
        rd1(8'h82, b);
        check("R5 pwm bit", 16'(b), 16'h80);
        check("R5 irq idle", 16'(irq_n), 16'h1);

        // R3 reset command
        wr1(8'h83, 8'h55);
        rd1(8'h82, b);
        check("R3 bad key", 16'(b), 16'h08);
        wr1(8'h83, 8'hAA);
        check("R3 cfg", 16'(cfg_reg), 16'h80);
        check("R3 act deb", 16'({act_time, debounce}), 16'h7D03);
        check("R3 size clk", 16'({key_size, clk_cfg}), 16'h3308);
        check("R3 gpio kept", gpio_dir, 16'h01F0);
        rd1(8'h82, b);
        check("R3 status", 16'(b), 16'h10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule